// File: doc/BRIEF.md
# Audio Automatic Level Controller

This block sets the 7-bit gain code of an input programmable-gain stage from the stereo samples that follow it. Each code step is 0.5 dB and code 0 is mute. A sample strobe carries one signed 16-bit left and right pair. When either channel reaches the selected limit threshold, the gain drops by a programmable number of codes. When enough quiet samples have passed, the gain rises by one or two codes. It never rises above a programmed reference code.

A level band just under the limit threshold restarts the quiet count, so a signal that sits close to the limit is never pushed back up into it. Gain updates can be held back until the signal crosses zero, which hides the step. A timeout limits how long a held update waits. One control byte selects the threshold, the step sizes, zero-cross gating and the enable. While the loop is off, the output simply follows the reference code.

Top module: `alc_ctrl`

## Requirements
- R1: While the enable bit is 0, `gain_o` equals `ref_i`. The quiet counter, the timeout counter, any pending update and the zero-cross history are cleared. When the loop is later enabled, it starts from the reference code.
- R2: The fields of `ctrl_i` are decoded by position: bit 5 enable, bit 4 zero-cross bypass, bits 3:2 attenuation select, bit 1 recovery select, bit 0 threshold select. Bits 7:6 are ignored.
- R3: A sample is a limit event when the absolute value of either channel is at or above the threshold. The threshold is 16423 when bit 0 is 0 and 20675 when bit 0 is 1.
- R4: A limit event lowers the gain by 1, 2, 3 or 4 codes for attenuation select 00, 01, 10 or 11. A result below 0 is clipped to 0.
- R5: After 8 consecutive quiet samples (the default `WAIT_SAMPLES`), the gain rises by 1 code when recovery select is 0 and by 2 codes when it is 1, clipped to `ref_i`. A gain already at or above `ref_i` is not raised.
- R6: A sample whose absolute value on either channel lies in the band below the threshold restarts the quiet count. The band is 13045 to 16422 for threshold select 0 and 16423 to 20674 for threshold select 1. Such a sample is neither quiet nor a limit event.
- R7: With the zero-cross bypass bit at 1, a gain change is visible on `gain_o` in the cycle after the strobe that caused it.
- R8: With the bypass bit at 0, a change is pending until a strobe where the sign bit of either channel differs from the previous strobe. It is applied at the latest on the `WAIT_SAMPLES`-th strobe after the request.
- R9: A limit event replaces a pending recovery. The pending change then becomes an attenuation.
- R10: Cycles without `smp_vld_i` do not change the gain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 8 | Control byte |
| ref_i | input | 7 | Reference (ceiling) gain code |
| smp_vld_i | input | 1 | Sample strobe |
| smp_l_i | input | 16 | Left sample, two's complement |
| smp_r_i | input | 16 | Right sample, two's complement |
| gain_o | output | 7 | Current gain code |

## Verification
Samples at one code below and exactly at each threshold, in both signs and on each channel alone, separate the compare edge from a sign or channel mistake. Runs of loud samples walk the gain down under every attenuation select until it clips at mute. Long quiet runs then walk it back up to the reference ceiling under both recovery steps. Band samples placed between quiet ones, for both threshold selects, show whether the quiet count is restarted rather than paused. With gating on, same-sign loud runs, a later sign flip, and a pending recovery overtaken by a limit event separate zero-cross release, timeout release and the priority rule.

// File: rtl/alc_ctrl.sv
module alc_ctrl #(
  parameter int SW           = 16,
  parameter int GW           = 7,
  parameter int WAIT_SAMPLES = 8,
  parameter int LVL_HI       = 20675,
  parameter int LVL_MID      = 16423,
  parameter int LVL_LO       = 13045
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    ctrl_i,
  input  logic [GW-1:0] ref_i,
  input  logic          smp_vld_i,
  input  logic [SW-1:0] smp_l_i,
  input  logic [SW-1:0] smp_r_i,
  output logic [GW-1:0] gain_o
);
  localparam int CW = $clog2(WAIT_SAMPLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_SAMPLES - 1);
  localparam logic [SW-1:0] K_HI  = SW'(LVL_HI);
  localparam logic [SW-1:0] K_MID = SW'(LVL_MID);
  localparam logic [SW-1:0] K_LO  = SW'(LVL_LO);

  logic en, zc_off, rec_sel, thr_sel;
  logic [1:0] att_sel;
  assign en      = ctrl_i[5];
  assign zc_off  = ctrl_i[4];
  assign att_sel = ctrl_i[3:2];
  assign rec_sel = ctrl_i[1];
  assign thr_sel = ctrl_i[0];

  logic [GW-1:0] gain_q;
  logic [CW-1:0] wcnt, tcnt;
  logic          pend_att, pend_rec, have_prev, sgn_l, sgn_r;

  logic [SW-1:0] mag_l, mag_r, thr, low;
  assign mag_l = smp_l_i[SW-1] ? (~smp_l_i + 1'b1) : smp_l_i;
  assign mag_r = smp_r_i[SW-1] ? (~smp_r_i + 1'b1) : smp_r_i;
  assign thr   = thr_sel ? K_HI : K_MID;
  assign low   = thr_sel ? K_MID : K_LO;

  logic over, band, quiet, w_exp, zc, want_att, want_rec, timeout, apply;
  assign over  = (mag_l >= thr) || (mag_r >= thr);
  assign band  = ((mag_l >= low) && (mag_l < thr)) || ((mag_r >= low) && (mag_r < thr));
  assign quiet = !over && !band;
  assign w_exp = quiet && (wcnt == LAST);
  assign zc    = have_prev && ((sgn_l != smp_l_i[SW-1]) || (sgn_r != smp_r_i[SW-1]));

  assign want_att = pend_att || over;
  assign want_rec = (pend_rec || w_exp) && !want_att;
  assign timeout  = (pend_att || pend_rec) && (tcnt == LAST);
  assign apply    = zc_off || zc || timeout;

  logic [2:0]    att_amt;
  logic [GW-1:0] att_ext, down, up;
  logic [GW:0]   sum;
  assign att_amt = {1'b0, att_sel} + 3'd1;
  assign att_ext = {{(GW-3){1'b0}}, att_amt};
  assign down    = (gain_q > att_ext) ? gain_q - att_ext : '0;
  assign sum     = {1'b0, gain_q} + {{(GW-1){1'b0}}, rec_sel, !rec_sel};
  assign up      = (gain_q >= ref_i) ? gain_q :
                   (sum > {1'b0, ref_i}) ? ref_i : sum[GW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q    <= '0;
      wcnt      <= '0;
      tcnt      <= '0;
      pend_att  <= 1'b0;
      pend_rec  <= 1'b0;
      have_prev <= 1'b0;
      sgn_l     <= 1'b0;
      sgn_r     <= 1'b0;
    end else if (!en) begin
      gain_q    <= ref_i;
      wcnt      <= '0;
      tcnt      <= '0;
      pend_att  <= 1'b0;
      pend_rec  <= 1'b0;
      have_prev <= 1'b0;
      sgn_l     <= 1'b0;
      sgn_r     <= 1'b0;
    end else if (smp_vld_i) begin
      have_prev <= 1'b1;
      sgn_l     <= smp_l_i[SW-1];
      sgn_r     <= smp_r_i[SW-1];
      wcnt      <= (!quiet || w_exp) ? '0 : wcnt + 1'b1;
      if ((want_att || want_rec) && apply) begin
        gain_q   <= want_att ? down : up;
        pend_att <= 1'b0;
        pend_rec <= 1'b0;
        tcnt     <= '0;
      end else begin
        pend_att <= want_att;
        pend_rec <= want_rec;
        tcnt     <= (pend_att || pend_rec) ? tcnt + 1'b1 : '0;
      end
    end
  end

  assign gain_o = en ? gain_q : ref_i;
endmodule

// File: rtl/alc_ctrl_chk.sv
module alc_ctrl_chk #(
  parameter int GW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    ctrl_i,
  input logic [GW-1:0] ref_i,
  input logic          smp_vld_i,
  input logic [GW-1:0] gain_o
);
  a_r1_start_at_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_i[5]) && $past(rst_n)) |-> gain_o == $past(ref_i));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[5] && $past(ctrl_i[5]) && !$past(smp_vld_i)) |-> gain_o == $past(gain_o));

  a_r4_drop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[5] && $past(ctrl_i[5]) && gain_o < $past(gain_o)) |-> ($past(gain_o) - gain_o) <= 7'd4);

  a_r5_rise_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[5] && $past(ctrl_i[5]) && gain_o > $past(gain_o)) |-> (gain_o - $past(gain_o)) <= 7'd2);

  a_r5_rise_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[5] && $past(ctrl_i[5]) && gain_o > $past(gain_o)) |-> gain_o <= $past(ref_i));
endmodule

bind alc_ctrl alc_ctrl_chk #(.GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .ref_i(ref_i),
  .smp_vld_i(smp_vld_i), .gain_o(gain_o)
);

// File: tb/alc_ctrl_tb_top.sv
module alc_ctrl_tb_top;
  localparam int WAIT = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic [6:0] refc = 7'h3F;
  logic vld = 1'b0;
  logic [15:0] sl = '0, sr = '0;
  logic [6:0] gain;

  always #10 clk = ~clk;

  alc_ctrl dut_i (.clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .ref_i(refc),
                  .smp_vld_i(vld), .smp_l_i(sl), .smp_r_i(sr), .gain_o(gain));

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  string req_q[$];
  string cur = "R1";

  int g = 0, w = 0, t = 0;
  bit pa = 0, pr = 0, hp = 0, psl = 0, psr = 0;

  function automatic int mag(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model(bit [7:0] c, int rf, bit v, int l, int r);
    int th, lo, ml, mr, amt;
    bit ov, bd, qt, ex, z, wa, wr, to;
    if (!c[5]) begin
      g = rf; w = 0; t = 0; pa = 0; pr = 0; hp = 0; psl = 0; psr = 0;
      return;
    end
    if (!v) return;
    th = c[0] ? 20675 : 16423;
    lo = c[0] ? 16423 : 13045;
    ml = mag(l); mr = mag(r);
    ov = (ml >= th) || (mr >= th);
    bd = (ml >= lo && ml < th) || (mr >= lo && mr < th);
    qt = !ov && !bd;
    ex = qt && (w == WAIT - 1);
    z  = hp && (((l < 0) != psl) || ((r < 0) != psr));
    wa = pa || ov;
    wr = (pr || ex) && !wa;
    to = (pa || pr) && (t == WAIT - 1);
    w  = (!qt || ex) ? 0 : w + 1;
    if ((wa || wr) && (c[4] || z || to)) begin
      if (wa) begin
        amt = c[3:2] + 1;
        g = (g > amt) ? g - amt : 0;
      end else if (g < rf) begin
        amt = c[1] ? 2 : 1;
        g = (g + amt > rf) ? rf : g + amt;
      end
      pa = 0; pr = 0; t = 0;
    end else begin
      t  = (pa || pr) ? t + 1 : 0;
      pa = wa; pr = wr;
    end
    hp = 1; psl = (l < 0); psr = (r < 0);
  endtask

  task automatic step(bit v, int l, int r);
    @(negedge clk);
    vld = v; sl = 16'(l); sr = 16'(r);
    model(ctrl, int'(refc), v, l, r);
    @(posedge clk);
    exp_q.push_back(ctrl[5] ? g : int'(refc));
    req_q.push_back(cur);
  endtask

  task automatic cfg(bit [7:0] c, int rf);
    @(negedge clk);
    ctrl = c; refc = 7'(rf); vld = 1'b0;
    model(c, rf, 1'b0, 0, 0);
    @(posedge clk);
    exp_q.push_back(c[5] ? g : rf);
    req_q.push_back(cur);
  endtask

  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      int e;
      string rq;
      e = exp_q.pop_front();
      rq = req_q.pop_front();
      n_cmp++;
      if (int'(gain) != e) begin
        n_bad++;
        $display("FAIL %s: gain=%0h expected=%0h at %0t", rq, gain, e, $time);
      end
    end
  end

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state and disabled loop ignores loud input
    cur = "R1";
    cfg(8'h00, 'h3F);
    step(1, 30000, -30000);
    cfg(8'h00, 'h20);
    step(1, 100, 100);
    cfg(8'h00, 'h3F);
    // R2 R3 R4 R7: bypass on, att 11, thr 0
    cur = "R3";
    cfg(8'h3C, 'h3F);
    step(1, 16422, 100);
    step(1, -16422, -16422);
    cur = "R4";
    step(1, 16423, 0);
    step(1, 0, -16423);
    cur = "R10";
    step(0, 32767, 32767);
    step(0, -32768, 0);
    cur = "R2";
    cfg(8'hF0, 'h3F);
    step(1, 17000, 0);
    cfg(8'h34, 'h3F);
    step(1, 17000, 0);
    cfg(8'h38, 'h3F);
    step(1, 0, 20000);
    cur = "R4";
    cfg(8'h3C, 'h3F);
    for (int i = 0; i < 20; i++) step(1, (i % 2) ? -32768 : 32767, 0);
    // R5: recovery +1 then +2, up to cap
    cur = "R5";
    for (int i = 0; i < 40; i++) step(1, 100, -100);
    cfg(8'h3E, 'h3F);
    for (int i = 0; i < 300; i++) step(1, 200, 50);
    cfg(8'h3E, 'h10);
    for (int i = 0; i < 20; i++) step(1, 200, 50);
    // R6: band restarts quiet count
    cur = "R6";
    cfg(8'h3C, 'h3F);
    step(1, 32767, 0);
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 5; i++) step(1, 10, 10);
      step(1, 0, 13045);
    end
    cfg(8'h3D, 'h3F);
    cur = "R3";
    step(1, 20674, 0);
    step(1, 0, -20675);
    cur = "R6";
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 6; i++) step(1, 10, 10);
      step(1, 16423, 0);
    end
    for (int i = 0; i < 12; i++) step(1, 10, 10);
    // R8: zero-cross gating and timeout
    cur = "R8";
    cfg(8'h2C, 'h3F);
    step(1, 100, 100);
    step(1, 17000, 100);
    step(1, 200, 100);
    step(1, -200, 100);
    step(1, 16500, 16500);
    for (int i = 0; i < 10; i++) step(1, 300, 300);
    step(1, 300, 20000);
    step(1, 300, -5);
    // R9: limit overtakes pending recovery
    cur = "R9";
    for (int i = 0; i < 9; i++) step(1, 50, 50);
    step(1, 18000, 50);
    step(1, 50, 50);
    step(1, -50, 50);
    for (int i = 0; i < 30; i++) step(1, (i % 3) ? 40 : -40, 40);
    // R1: disable returns to reference, re-enable starts there
    cur = "R1";
    cfg(8'h00, 'h2A);
    step(1, 30000, 30000);
    cfg(8'h3C, 'h2A);
    step(1, 30000, 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule